// File: doc/BRIEF.md
# Prescaled 9-bit PWM generator

This block drives one pulse-width-modulated output from a single system clock. Three reference-rate tick strobes arrive as one-cycle enables. A 2-bit source code picks one of them, or none. The picked tick passes through a pre-divider whose ratio is one of 1, 3, 5 or 6, then through a power-of-two stage that divides by 2^E. Each tick that leaves this chain advances a 9-bit period counter. The output is in its active level while the counter is below a 9-bit compare value. A polarity bit can invert it.

Software loads the source code, the pre-divide code, the exponent, the compare value, the polarity and the enable into a shadow copy with a write strobe. A separate commit pulse moves the whole shadow copy into the live settings as one unit, so that no period runs on a mix of old and new settings. A control state machine sets when the commit takes effect. It has three states. `S_IDLE` means the live enable is off. `S_RUN` means the generator is running and no commit is waiting. `S_ARMED` means the generator is running and a commit waits for the counter wrap. Its transitions are:

- `IDLE_COMMIT`: from `S_IDLE`, a commit applies on the next edge.
- `RUN_COMMIT_WRAP`: from `S_RUN`, a commit that lands in the wrap cycle applies at that wrap.
- `RUN_ARM`: from `S_RUN`, a commit in any other cycle moves to `S_ARMED`.
- `ARMED_WRAP`: from `S_ARMED`, the next wrap applies the shadow copy.
- `DEAD_CLOCK`: from `S_RUN` or `S_ARMED`, a commit applies at once while no source is selected.

Each transfer goes to `S_RUN` or `S_IDLE` according to the enable bit it carries.

Top module: `prescaled_pwm`

## Requirements
- R1: After reset, `pwm_out` is 0 and the generator is disabled with normal polarity.
- R2: Source codes 0, 1 and 2 select `ref_stb[0]`, `ref_stb[1]` and `ref_stb[2]`. Pre-divide codes 0, 1, 2 and 3 divide by 1, 3, 5 and 6. One period lasts 512 × ratio × 2^E selected strobes.
- R3: With normal polarity, the output is high for compare × ratio × 2^E strobes of each period. A compare value of 0 never drives it high, and 511 keeps it high for all but one count.
- R4: When the polarity bit is 1, the output is the complement of the R3 waveform.
- R5: Source code 3 selects no clock. The counter then holds, the output stays constant, and a commit takes effect at once.
- R6: While the live enable is 0, the output stays at the polarity bit's level (0 for normal polarity, 1 for inverted) and the counters are held at 0.
- R7: A shadow write without a commit does not change the output.
- R8: A commit while disabled updates the live settings on its own clock edge, and the output follows one edge later.
- R9: A commit while running is deferred to the next counter wrap. The high phase in progress finishes with the old compare value.
- R10: A commit sampled in the wrap cycle itself (count 511 with a tick) applies at that wrap. A commit one cycle later waits a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_stb | input | NREF (3) | One-cycle reference tick strobes |
| cfg_wr | input | 1 | Loads the cfg_* fields into the shadow copy |
| cfg_src | input | 2 | Reference source code (3 = none) |
| cfg_pdiv | input | 2 | Pre-divide code (ratios 1, 3, 5, 6) |
| cfg_exp | input | 3 | Power-of-two exponent E |
| cfg_cmp | input | 9 | Compare (duty) value |
| cfg_inv | input | 1 | Output polarity (1 = inverted) |
| cfg_en | input | 1 | Generator enable |
| cfg_commit | input | 1 | Moves the shadow copy into the live settings |
| pwm_out | output | 1 | Registered PWM output |

## Verification
Two events can fall in the same cycle: the counter wrap and a commit pulse. The bench takes the output's rising edge as its phase reference. From it, the bench counts forward to the wrap cycle and places a commit exactly there, then places another commit one cycle later. It then measures the length of the next high phase. That length must show the new compare value in the first case and the old one for one more period in the second. A commit placed in the middle of a high phase must leave that phase shorter than the old compare length.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    parameter int RES_W  = 9;   // period counter resolution
    parameter int SRC_W  = 2;   // reference select code width
    parameter int PDIV_W = 2;   // pre-divide code width
    parameter int EXP_W  = 3;   // power-of-two exponent width
    parameter int RAT_W  = 3;   // width of a pre-divide ratio value

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic [PDIV_W-1:0] pdiv;
        logic [EXP_W-1:0]  expo;
        logic [RES_W-1:0]  cmp;
        logic              inv;
        logic              en;
    } pwm_cfg_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_ARMED = 2'd2
    } ctl_state_e;

    // Non-binary pre-divide set: code -> ratio
    function automatic logic [RAT_W-1:0] pdiv_ratio(input logic [PDIV_W-1:0] code);
        logic [RAT_W-1:0] r;
        unique case (code)
            2'd0:    r = 3'd1;
            2'd1:    r = 3'd3;
            2'd2:    r = 3'd5;
            default: r = 3'd6;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm_tick_chain.sv
// Reference select, odd/even pre-divider and power-of-two stage.
module pwm_tick_chain
    import pwm_pkg::*;
#(
    parameter int NREF = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREF-1:0]   ref_stb,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [PDIV_W-1:0] pdiv_i,
    input  logic [EXP_W-1:0]  expo_i,
    input  logic              clr_i,
    output logic              step_o,
    output logic              dead_o
);

    localparam int ECNT_W = (1 << EXP_W) - 1;

    logic              ref_tick;
    logic              pre_last;
    logic              pre_tick;
    logic [RAT_W-1:0]  ratio;
    logic [RAT_W-1:0]  pcnt_q;
    logic [ECNT_W-1:0] ecnt_q;
    logic [ECNT_W-1:0] exp_lim;
    logic              exp_last;

    // Source select; a code outside the strobe range selects nothing.
    always_comb begin
        ref_tick = 1'b0;
        dead_o   = 1'b1;
        for (int i = 0; i < NREF; i++) begin
            if (src_i == SRC_W'(i)) begin
                ref_tick = ref_stb[i];
                dead_o   = 1'b0;
            end
        end
    end

    assign ratio    = pdiv_ratio(pdiv_i);
    assign pre_last = (pcnt_q == ratio - RAT_W'(1));
    assign pre_tick = ref_tick && pre_last;
    assign exp_lim  = ECNT_W'((32'd1 << expo_i) - 32'd1);
    assign exp_last = (ecnt_q == exp_lim);
    assign step_o   = pre_tick && exp_last;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            pcnt_q <= '0;
            ecnt_q <= '0;
        end else begin
            if (ref_tick) begin
                pcnt_q <= pre_last ? '0 : pcnt_q + RAT_W'(1);
            end
            if (pre_tick) begin
                ecnt_q <= exp_last ? '0 : ecnt_q + ECNT_W'(1);
            end
        end
    end

    // R2: pre-divide count never reaches the selected ratio
    assert_prediv_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q < ratio);

    // R2: exponent count stays within 2^E - 1
    assert_expcnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ecnt_q <= exp_lim);

endmodule

// File: rtl/pwm_period_ctr.sv
// Fixed-resolution period counter advanced by the tick chain.
module pwm_period_ctr
    import pwm_pkg::*;
#(
    parameter int W = RES_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = step_i && (cnt_q == CNT_MAX);

    // R5: without a tick or clear the count does not move
    assert_hold_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_cfg_ctrl.sv
// Shadow/live configuration and the commit state machine.
module pwm_cfg_ctrl
    import pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  pwm_cfg_t   cfg_in,
    input  logic       commit_i,
    input  logic       wrap_i,
    input  logic       dead_i,
    output pwm_cfg_t   live_o,
    output ctl_state_e state_o,
    output logic       xfer_o
);

    ctl_state_e state_q, state_d;
    pwm_cfg_t   shadow_q, shadow_nx, live_q;
    logic       boundary;

    assign shadow_nx = cfg_wr ? cfg_in : shadow_q;
    assign boundary  = wrap_i || dead_i;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and transfer strobe
    always_comb begin
        state_d = state_q;
        xfer_o  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (commit_i) begin                      // IDLE_COMMIT
                    xfer_o  = 1'b1;
                    state_d = shadow_nx.en ? S_RUN : S_IDLE;
                end
            end
            S_RUN: begin
                if (commit_i) begin
                    if (boundary) begin                  // RUN_COMMIT_WRAP / DEAD_CLOCK
                        xfer_o  = 1'b1;
                        state_d = shadow_nx.en ? S_RUN : S_IDLE;
                    end else begin                       // RUN_ARM
                        state_d = S_ARMED;
                    end
                end
            end
            S_ARMED: begin
                if (boundary) begin                      // ARMED_WRAP / DEAD_CLOCK
                    xfer_o  = 1'b1;
                    state_d = shadow_nx.en ? S_RUN : S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Shadow and live copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            live_q   <= '0;
        end else begin
            shadow_q <= shadow_nx;
            if (xfer_o) begin
                live_q <= shadow_nx;
            end
        end
    end

    assign live_o  = live_q;
    assign state_o = state_q;

    // R7: live settings only move on a transfer
    assert_live_only_on_transfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_o |=> $stable(live_q));

    // R9: a pending commit stays pending until a boundary
    assert_armed_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARMED && !boundary) |=> state_q == S_ARMED);

endmodule

// File: rtl/prescaled_pwm.sv
module prescaled_pwm
    import pwm_pkg::*;
#(
    parameter int NREF = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREF-1:0]   ref_stb,
    input  logic              cfg_wr,
    input  logic [SRC_W-1:0]  cfg_src,
    input  logic [PDIV_W-1:0] cfg_pdiv,
    input  logic [EXP_W-1:0]  cfg_exp,
    input  logic [RES_W-1:0]  cfg_cmp,
    input  logic              cfg_inv,
    input  logic              cfg_en,
    input  logic              cfg_commit,
    output logic              pwm_out
);

    pwm_cfg_t   cfg_in, live;
    ctl_state_e state;
    logic       xfer, step, dead, wrap, clr, running;
    logic [RES_W-1:0] cnt;
    logic       pwm_q;

    assign cfg_in = '{src: cfg_src, pdiv: cfg_pdiv, expo: cfg_exp,
                      cmp: cfg_cmp, inv: cfg_inv, en: cfg_en};

    pwm_cfg_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_in   (cfg_in),
        .commit_i (cfg_commit),
        .wrap_i   (wrap),
        .dead_i   (dead),
        .live_o   (live),
        .state_o  (state),
        .xfer_o   (xfer)
    );

    // Counters are cleared while disabled and on every transfer,
    // so partial pre-divide and exponent counts never carry over.
    assign running = (state != S_IDLE) && live.en;
    assign clr     = xfer || !running;

    pwm_tick_chain #(.NREF(NREF)) u_ticks (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_stb (ref_stb),
        .src_i   (live.src),
        .pdiv_i  (live.pdiv),
        .expo_i  (live.expo),
        .clr_i   (clr),
        .step_o  (step),
        .dead_o  (dead)
    );

    pwm_period_ctr #(.W(RES_W)) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .clr_i  (clr),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    // Registered output: no glitch from compare of changing registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else if (!running) begin
            pwm_q <= live.inv;
        end else begin
            pwm_q <= (cnt < live.cmp) ^ live.inv;
        end
    end

    assign pwm_out = pwm_q;

    // R6: a generator disabled for two cycles has its counter at 0
    assert_idle_count_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && $past(state == S_IDLE)) |-> cnt == '0);

    // R10: a wrap while running or armed always consumes a pending commit
    assert_wrap_consumes_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARMED && wrap) |-> xfer);

endmodule

// File: tb/prescaled_pwm_bench.sv
module prescaled_pwm_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] ref_stb;
    logic       cfg_wr, cfg_inv, cfg_en, cfg_commit;
    logic [1:0] cfg_src, cfg_pdiv;
    logic [2:0] cfg_exp;
    logic [8:0] cfg_cmp;
    logic       pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    prescaled_pwm u_prescaled_pwm (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb),
        .cfg_wr(cfg_wr), .cfg_src(cfg_src), .cfg_pdiv(cfg_pdiv),
        .cfg_exp(cfg_exp), .cfg_cmp(cfg_cmp), .cfg_inv(cfg_inv),
        .cfg_en(cfg_en), .cfg_commit(cfg_commit), .pwm_out(pwm_out)
    );

    // Strobes: source 0 every cycle, source 1 every 2nd, source 2 every 3rd.
    initial begin
        int k = 0;
        ref_stb = 3'b000;
        forever begin
            @(negedge clk);
            k++;
            ref_stb[0] = 1'b1;
            ref_stb[1] = (k % 2 == 0);
            ref_stb[2] = (k % 3 == 0);
        end
    end

    typedef struct packed {
        logic [1:0] src;
        logic [1:0] pd;
        logic [2:0] ex;
        logic [8:0] cmp;
        logic       inv;
        int         per;
        int         hi;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd0, 3'd0, 9'd100, 1'b0,  512,   100},
        '{2'd0, 2'd1, 3'd1, 9'd256, 1'b0,  3072,  1536},
        '{2'd1, 2'd2, 3'd0, 9'd511, 1'b1,  5120,  10},
        '{2'd2, 2'd3, 3'd0, 9'd0,   1'b0,  9216,  0},
        '{2'd0, 2'd0, 3'd3, 9'd1,   1'b0,  4096,  8},
        '{2'd0, 2'd3, 3'd2, 9'd0,   1'b1,  12288, 12288},
        '{2'd0, 2'd0, 3'd4, 9'd300, 1'b0,  8192,  4800},
        '{2'd1, 2'd1, 3'd0, 9'd511, 1'b0,  3072,  3066}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [1:0] s, input logic [1:0] p, input logic [2:0] e,
                          input logic [8:0] c, input logic i, input logic en, input logic cm);
        @(negedge clk);
        cfg_src = s; cfg_pdiv = p; cfg_exp = e; cfg_cmp = c;
        cfg_inv = i; cfg_en = en; cfg_wr = 1'b1; cfg_commit = cm;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_commit = 1'b0;
    endtask

    task automatic count_high(input int win, output int h);
        h = 0;
        repeat (win) begin
            @(negedge clk);
            if (pwm_out) h++;
        end
    endtask

    task automatic wait_rise();
        bit p;
        p = pwm_out;
        @(negedge clk);
        while (!(!p && pwm_out)) begin
            p = pwm_out;
            @(negedge clk);
        end
    endtask

    task automatic run_len(output int n);
        n = 0;
        while (pwm_out) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic rise_period(output int n);
        bit p;
        wait_rise();
        n = 0;
        p = 1'b1;
        forever begin
            @(negedge clk);
            n++;
            if (!p && pwm_out) break;
            p = pwm_out;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int h, n, prev_per, changes;
        bit last;
        rst_n = 1'b0; cfg_wr = 0; cfg_commit = 0;
        cfg_src = 0; cfg_pdiv = 0; cfg_exp = 0; cfg_cmp = 0; cfg_inv = 0; cfg_en = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R1", "output after reset", pwm_out, 0);

        // Table walk
        prev_per = 16;
        for (int i = 0; i < NV; i++) begin
            vec_t v = VEC[i];
            wr_cfg(v.src, v.pd, v.ex, v.cmp, v.inv, 1'b0, 1'b1);
            repeat (prev_per + 16) @(negedge clk);
            wr_cfg(v.src, v.pd, v.ex, v.cmp, v.inv, 1'b1, 1'b1);
            repeat (8) @(negedge clk);
            count_high(v.per, h);
            check(h == v.hi, v.inv ? "R4" : "R3", "high cycles per period", h, v.hi);
            if (v.hi > 0 && v.hi < v.per) begin
                rise_period(n);
                check(n == v.per, "R2", "period length", n, v.per);
            end
            prev_per = v.per;
        end

        // R6: disable with inverted polarity; output holds high
        wr_cfg(2'd0, 2'd0, 3'd0, 9'd0, 1'b1, 1'b0, 1'b1);
        repeat (prev_per + 16) @(negedge clk);
        count_high(300, h);
        check(h == 300, "R6", "inverted idle level cycles", h, 300);

        // R8: commit while disabled; live on its edge, output one edge later
        @(negedge clk);
        cfg_inv = 1'b0; cfg_en = 1'b0; cfg_wr = 1'b1; cfg_commit = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_commit = 1'b0;
        check(pwm_out == 1'b1, "R8", "output before follow edge", pwm_out, 1);
        @(negedge clk);
        check(pwm_out == 1'b0, "R8", "output after follow edge", pwm_out, 0);
        count_high(100, h);
        check(h == 0, "R6", "normal idle level cycles", h, 0);

        // R7 / R9: running at cmp 100, period 512
        wr_cfg(2'd0, 2'd0, 3'd0, 9'd100, 1'b0, 1'b1, 1'b1);
        repeat (600) @(negedge clk);
        wr_cfg(2'd0, 2'd0, 3'd0, 9'd400, 1'b0, 1'b1, 1'b0);
        count_high(512, h);
        check(h == 100, "R7", "high cycles after write only", h, 100);
        wait_rise();
        repeat (20) @(negedge clk);
        @(negedge clk); cfg_commit = 1'b1;
        @(negedge clk); cfg_commit = 1'b0;
        run_len(n);
        check(n < 100, "R9", "rest of high phase in progress", n, 100);
        wait_rise();
        run_len(n);
        check(n == 400, "R9", "first full high phase after commit", n, 400);

        // R10: commit in the wrap cycle applies at that wrap
        wr_cfg(2'd0, 2'd0, 3'd0, 9'd200, 1'b0, 1'b1, 1'b0);
        wait_rise();
        repeat (510) @(negedge clk);
        cfg_commit = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0;
        wait_rise();
        run_len(n);
        check(n == 200, "R10", "high phase after commit in wrap cycle", n, 200);

        // R10: commit one cycle after the wrap waits a full period
        wr_cfg(2'd0, 2'd0, 3'd0, 9'd50, 1'b0, 1'b1, 1'b0);
        wait_rise();
        repeat (511) @(negedge clk);
        cfg_commit = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0;
        run_len(n);
        check(n == 200, "R10", "high phase after late commit (old)", n, 200);
        wait_rise();
        run_len(n);
        check(n == 50, "R10", "next high phase after late commit", n, 50);

        // R5: no clock selected; output constant, commit applies at once
        wr_cfg(2'd0, 2'd0, 3'd0, 9'd50, 1'b0, 1'b0, 1'b1);
        repeat (600) @(negedge clk);
        wr_cfg(2'd3, 2'd0, 3'd0, 9'd100, 1'b0, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        check(pwm_out == 1'b1, "R5", "output with no clock", pwm_out, 1);
        changes = 0;
        last = pwm_out;
        repeat (1000) begin
            @(negedge clk);
            if (pwm_out != last) changes++;
            last = pwm_out;
        end
        check(changes == 0, "R5", "output changes with no clock", changes, 0);
        wr_cfg(2'd0, 2'd0, 3'd0, 9'd0, 1'b0, 1'b1, 1'b1);
        repeat (2) @(negedge clk);
        check(pwm_out == 1'b0, "R5", "commit applied at once with no clock", pwm_out, 0);

        finish_run();
    end

endmodule